// File: doc/BRIEF.md
# Byte Substitution Unit with Two-Way Parity Checking

This block computes the forward AES byte substitution of an 8-bit value. It also runs a concurrent check that needs no parity bits stored next to the substitution data. Two one-bit predictors watch the datapath.

- The forward predictor looks at the incoming byte. It forecasts the parity that the substituted byte ought to have.
- The backward predictor looks at the substituted byte. Because the substitution is a permutation, that byte determines which input produced it. The predictor therefore forecasts the parity of that input without building an inverse substitution datapath.

Each forecast is compared with the parity actually seen on its side. A disagreement on either side raises the error flag.

The unit is purely combinational. The substituted byte and the error flags settle together, within the same cycle as the input. Two test-only masks can corrupt the lookup in two ways: one flips bits of the table index, and the other flips bits of the table output. They let a test show that both predictors are alive. Both masks are tied to zero in mission mode. The unit does not recover from or retry after an error.

Top module: `sbox_dualpar_chk`

## Requirements
- R1: With both fault masks zero, `dout` equals the AES forward substitution of `din`. That substitution is the multiplicative inverse in GF(2^8) under the polynomial 0x11B, with zero taken as its own inverse. It is followed by the affine map `b ^ rotl(b,1) ^ rotl(b,2) ^ rotl(b,3) ^ rotl(b,4) ^ 8'h63`. Examples: 8'h00 gives 8'h63 and 8'h53 gives 8'hED.
- R2: With both fault masks zero, `err_out_side`, `err_in_side` and `err` are 0 for every one of the 256 input values.
- R3: Parity of a byte is the XOR of its eight bits. `err_out_side` is 1 exactly when the parity of `dout` differs from the parity of the substitution of `din`. Known pairs (input, input parity, output, output parity) are:
  - 8'h04, 1, 8'hF2, 1
  - 8'h13, 1, 8'h7D, 0
  - 8'h11, 0, 8'h82, 0
  - 8'h15, 1, 8'h59, 0
- R4: `err_in_side` is 1 exactly when the parity of `din` differs from the parity of the unique byte whose substitution equals `dout`.
- R5: `err` is 1 exactly when at least one of `err_out_side` and `err_in_side` is 1.
- R6: `fi_data_mask` is XORed onto the table output before both checkers, so `dout` equals the substitution of `din` XOR the mask. Any mask with exactly one bit set, with `fi_addr_mask` zero, drives `err_out_side` and `err` to 1.
- R7: `fi_addr_mask` is XORed onto the table index, so `dout` equals the substitution of (`din` XOR mask). Any mask with exactly one bit set, with `fi_data_mask` zero, drives `err_in_side` and `err` to 1.
- R8: All outputs follow a change of any input without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| din | input | 8 | Byte to substitute |
| fi_addr_mask | input | 8 | Test-only XOR mask applied to the lookup index; zero in mission mode |
| fi_data_mask | input | 8 | Test-only XOR mask applied to the lookup result; zero in mission mode |
| dout | output | 8 | Substituted byte |
| err_out_side | output | 1 | Parity of `dout` disagrees with the forecast made from `din` |
| err_in_side | output | 1 | Parity of `din` disagrees with the forecast made from `dout` |
| err | output | 1 | Either mismatch present |

## Verification
A corrupted table entry or a broken forward predictor shows up in the same cycle as a wrong `dout` byte. It may also show up as a spurious `err_out_side` for that one input value only. A sweep of all 256 inputs therefore exposes it, while sparse sampling can miss it.

A broken backward predictor stays silent until its output is needed. It shows up either as `err_in_side` set on clean data, or as `err_in_side` staying low while an index bit is flipped.

The bench computes each byte by brute-force inverse search and a rotation-based affine map. It drives every single-bit mask on both hooks and compares all four outputs a few nanoseconds after each input change.

// File: rtl/sbox_chk_pkg.sv
package sbox_chk_pkg;

  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned N_ENTRIES = 1 << BYTE_W;
  localparam logic [7:0]  AFF_CONST = 8'h63;
  localparam logic [7:0]  RED_POLY  = 8'h1B;

  typedef logic [BYTE_W-1:0] byte_t;

  // Carry-less multiply reduced by x^8+x^4+x^3+x+1.
  function automatic byte_t gf_mul(input byte_t a, input byte_t b);
    byte_t acc;
    byte_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[6:0], 1'b0} ^ (sh[7] ? RED_POLY : 8'h00);
    end
    return acc;
  endfunction

  // a^254 by square-and-multiply; zero yields zero.
  function automatic byte_t gf_inv(input byte_t a);
    byte_t r;
    byte_t base;
    logic [7:0] e;
    r    = 8'h01;
    base = a;
    e    = 8'd254;
    for (int i = 0; i < BYTE_W; i++) begin
      if (e[i]) r = gf_mul(r, base);
      base = gf_mul(base, base);
    end
    return r;
  endfunction

  function automatic byte_t affine_fwd(input byte_t b);
    byte_t o;
    for (int i = 0; i < BYTE_W; i++) begin
      o[i] = b[i] ^ b[(i+4)%8] ^ b[(i+5)%8] ^ b[(i+6)%8] ^ b[(i+7)%8] ^ AFF_CONST[i];
    end
    return o;
  endfunction

  function automatic byte_t sub_fwd(input byte_t x);
    return affine_fwd(gf_inv(x));
  endfunction

  function automatic logic par8(input byte_t x);
    return ^x;
  endfunction

endpackage

// File: rtl/sbox_lut.sv
module sbox_lut
  import sbox_chk_pkg::*;
#(
  parameter int unsigned DEPTH = N_ENTRIES
) (
  input  byte_t idx,
  output byte_t data
);
  localparam int unsigned IDX_W = $clog2(DEPTH);

  byte_t tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    localparam byte_t ROWVAL = sub_fwd(byte_t'(g));
    assign tbl[g] = ROWVAL;
  end

  assign data = tbl[idx[IDX_W-1:0]];

endmodule

// File: rtl/par_fwd_pred.sv
// Forecasts parity of the substituted byte from the input byte.
module par_fwd_pred
  import sbox_chk_pkg::*;
#(
  parameter int unsigned DEPTH = N_ENTRIES
) (
  input  byte_t x,
  output logic  pred
);
  logic [DEPTH-1:0] ptab;

  for (genvar g = 0; g < DEPTH; g++) begin : g_bit
    localparam logic PB = par8(sub_fwd(byte_t'(g)));
    assign ptab[g] = PB;
  end

  assign pred = ptab[x];

endmodule

// File: rtl/par_bwd_pred.sv
// Forecasts parity of the pre-image of a substituted byte. The table is
// filled by scattering: row g lands at position sub_fwd(g), so no inverse
// substitution datapath exists.
module par_bwd_pred
  import sbox_chk_pkg::*;
#(
  parameter int unsigned DEPTH = N_ENTRIES
) (
  input  byte_t y,
  output logic  pred
);
  logic [DEPTH-1:0] ptab;

  for (genvar g = 0; g < DEPTH; g++) begin : g_bit
    localparam byte_t DST = sub_fwd(byte_t'(g));
    localparam logic  PB  = par8(byte_t'(g));
    assign ptab[DST] = PB;
  end

  assign pred = ptab[y];

endmodule

// File: rtl/sbox_dualpar_chk.sv
module sbox_dualpar_chk
  import sbox_chk_pkg::*;
#(
  parameter bit FAULT_HOOKS = 1'b1
) (
  input  logic [7:0] din,
  input  logic [7:0] fi_addr_mask,
  input  logic [7:0] fi_data_mask,
  output logic [7:0] dout,
  output logic       err_out_side,
  output logic       err_in_side,
  output logic       err
);
  byte_t lut_idx;
  byte_t lut_raw;
  byte_t sub_q;
  logic  fwd_pred;
  logic  bwd_pred;
  logic  seen_out_par;
  logic  seen_in_par;

  if (FAULT_HOOKS) begin : g_hooks
    assign lut_idx = din ^ fi_addr_mask;
    assign sub_q   = lut_raw ^ fi_data_mask;
  end else begin : g_nohooks
    logic unused_masks;
    assign unused_masks = ^{fi_addr_mask, fi_data_mask};
    assign lut_idx = din;
    assign sub_q   = lut_raw;
  end

  sbox_lut u_lut (
    .idx  (lut_idx),
    .data (lut_raw)
  );

  // forward forecast uses the true input, not the (possibly faulted) index
  par_fwd_pred u_fwd (
    .x    (din),
    .pred (fwd_pred)
  );

  par_bwd_pred u_bwd (
    .y    (sub_q),
    .pred (bwd_pred)
  );

  always_comb begin
    seen_out_par = ^sub_q;
    seen_in_par  = ^din;
  end

  assign dout         = sub_q;
  assign err_out_side = seen_out_par ^ fwd_pred;
  assign err_in_side  = seen_in_par ^ bwd_pred;
  assign err          = err_out_side | err_in_side;

  always_comb begin
    if (fi_addr_mask == 8'h00 && fi_data_mask == 8'h00) begin
      assert_clean_quiet_R2: assert (!err)
        else $error("error flag set on clean lookup");
      assert_bwd_pred_match_R4: assert (bwd_pred == ^din)
        else $error("backward forecast disagrees with input parity");
    end
    if (fi_addr_mask == 8'h00 && $countones(fi_data_mask) == 1) begin
      assert_data_flip_seen_R6: assert (err_out_side && err)
        else $error("data-side single flip not flagged");
    end
    if (fi_data_mask == 8'h00 && $countones(fi_addr_mask) == 1) begin
      assert_addr_flip_seen_R7: assert (err_in_side && err)
        else $error("index-side single flip not flagged");
    end
  end

endmodule

// File: tb/tb_sbox_dualpar_chk.sv
`timescale 1ns/1ps
module tb_sbox_dualpar_chk;

  logic       clk;
  logic       rst_n;
  logic [7:0] din;
  logic [7:0] fi_addr_mask;
  logic [7:0] fi_data_mask;
  logic [7:0] dout;
  logic       err_out_side;
  logic       err_in_side;
  logic       err;

  int total;
  int bad;
  bit done;

  sbox_dualpar_chk dut (
    .din          (din),
    .fi_addr_mask (fi_addr_mask),
    .fi_data_mask (fi_data_mask),
    .dout         (dout),
    .err_out_side (err_out_side),
    .err_in_side  (err_in_side),
    .err          (err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // reference model, written independently of the RTL
  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p;
    p = 16'h0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
    for (int k = 15; k >= 8; k--) if (p[k]) p = p ^ (16'h011B << (k - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] m_inv(input logic [7:0] a);
    logic [7:0] r;
    r = 8'h00;
    for (int c = 1; c < 256; c++) if (m_mul(a, 8'(c)) == 8'h01) r = 8'(c);
    return r;
  endfunction

  function automatic logic [7:0] rotl(input logic [7:0] b, input int n);
    return (b << n) | (b >> (8 - n));
  endfunction

  function automatic logic [7:0] m_sub(input logic [7:0] x);
    logic [7:0] v;
    v = m_inv(x);
    return v ^ rotl(v, 1) ^ rotl(v, 2) ^ rotl(v, 3) ^ rotl(v, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] m_pre(input logic [7:0] y);
    logic [7:0] r;
    r = 8'h00;
    for (int c = 0; c < 256; c++) if (m_sub(8'(c)) == y) r = 8'(c);
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] d, input logic [7:0] am, input logic [7:0] dm);
    @(posedge clk);
    #2;
    din = d; fi_addr_mask = am; fi_data_mask = dm;
    #3;
  endtask

  // checks every output against the model for current stimulus
  task automatic full_check(input string tag);
    logic [7:0] eo;
    logic eos, eis;
    eo  = m_sub(din ^ fi_addr_mask) ^ fi_data_mask;
    eos = (^eo) ^ (^m_sub(din));
    eis = (^din) ^ (^m_pre(eo));
    chk({tag, " R1/R6/R7 dout"}, 32'(dout), 32'(eo));
    chk({tag, " R3 err_out_side"}, 32'(err_out_side), 32'(eos));
    chk({tag, " R4 err_in_side"}, 32'(err_in_side), 32'(eis));
    chk({tag, " R5 err"}, 32'(err), 32'(eos | eis));
  endtask

  initial begin
    total = 0; bad = 0; done = 1'b0;
    rst_n = 1'b0;
    din = 8'h00; fi_addr_mask = 8'h00; fi_data_mask = 8'h00;
    void'($urandom(32'd4242));
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;

    // initial state: input zero, no faults
    #3;
    chk("R1 zero maps to 63", 32'(dout), 32'h63);
    chk("R2 idle err", 32'(err), 32'h0);

    // R8: outputs follow input mid-cycle, no clock edge in between
    @(negedge clk);
    din = 8'h53;
    #1;
    chk("R8 same-cycle dout", 32'(dout), 32'hED);
    chk("R8 same-cycle err", 32'(err), 32'h0);

    // R3 reference rows
    apply(8'h04, 8'h00, 8'h00);
    chk("R3 row04 dout", 32'(dout), 32'hF2); chk("R3 row04 par", 32'(^dout), 32'h1);
    apply(8'h13, 8'h00, 8'h00);
    chk("R3 row13 dout", 32'(dout), 32'h7D); chk("R3 row13 par", 32'(^dout), 32'h0);
    apply(8'h11, 8'h00, 8'h00);
    chk("R3 row11 dout", 32'(dout), 32'h82); chk("R3 row11 par", 32'(^dout), 32'h0);
    apply(8'h15, 8'h00, 8'h00);
    chk("R3 row15 dout", 32'(dout), 32'h59); chk("R3 row15 par", 32'(^dout), 32'h0);

    // R1/R2: exhaustive clean sweep
    for (int v = 0; v < 256; v++) begin
      apply(8'(v), 8'h00, 8'h00);
      chk("R1 sweep dout", 32'(dout), 32'(m_sub(8'(v))));
      chk("R2 sweep err", 32'({err_out_side, err_in_side, err}), 32'h0);
    end

    // R6: single data-bit flips
    for (int b = 0; b < 8; b++) begin
      for (int k = 0; k < 6; k++) begin
        apply(8'($urandom), 8'h00, 8'(1 << b));
        chk("R6 data flip err_out_side", 32'(err_out_side), 32'h1);
        chk("R6 data flip err", 32'(err), 32'h1);
        full_check("R6");
      end
    end

    // R7: single index-bit flips
    for (int b = 0; b < 8; b++) begin
      for (int k = 0; k < 6; k++) begin
        apply(8'($urandom), 8'(1 << b), 8'h00);
        chk("R7 addr flip err_in_side", 32'(err_in_side), 32'h1);
        chk("R7 addr flip err", 32'(err), 32'h1);
        full_check("R7");
      end
    end

    // corner: both masks all-ones, and random mixed faults
    apply(8'hFF, 8'hFF, 8'hFF);
    full_check("R5 all-ones masks");
    for (int k = 0; k < 300; k++) begin
      apply(8'($urandom), 8'($urandom), 8'($urandom));
      full_check("R5 random");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule